// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two IEEE-754 single-precision operands, `ra` and `rb`, under a 3-bit condition selector. It returns a 32-bit word that is either 0 or 1, plus an invalid-operation flag for the status unit. NaNs, signed zeros, infinities and subnormal values are all handled as ordinary encodings. Rounding plays no part. Traps are raised elsewhere.

Each condition fixes the order in which the operands are used. The not-equal and greater-or-equal conditions are logical complements of other tests, so both return true when either input is a NaN. The equality-style conditions are quiet and flag invalid only on a signaling NaN. The ordering conditions flag invalid on any NaN. Selector value 7 has no defined comparison and is reported on a separate output.

The comparison core is combinational. A parameter places an optional result register behind it, and a valid strobe travels with each operation.

Top module: `fcmp_unit`

## Requirements
- R1: With `REG_OUT`=1, an operation presented with `in_valid` high at a clock edge appears with `out_valid` high after that edge. `result` bits 31..1 are always zero. When `out_valid` is low, `result`, `invalid` and `unsupported` are all zero.
- R2: `cond`=0 (unordered) returns 1 when either operand is a NaN and 0 otherwise. It raises `invalid` only for a signaling NaN. A NaN has exponent field all ones and a nonzero fraction. It is signaling when fraction bit 22 is 0.
- R3: `cond`=1 returns 1 exactly when rb < ra.
- R4: `cond`=2 returns 1 when ra equals rb. +0 equals -0, and a NaN equals nothing. `invalid` is raised only for a signaling NaN.
- R5: `cond`=3 returns 1 exactly when ra <= rb.
- R6: `cond`=4 returns 1 exactly when ra < rb.
- R7: `cond`=5 returns the complement of the equality test, so it returns 1 when either operand is a NaN. `invalid` is raised only for a signaling NaN.
- R8: `cond`=6 returns the complement of (ra < rb), so it returns 1 when either operand is a NaN.
- R9: Conditions 1, 3, 4 and 6 raise `invalid` for any NaN input, quiet or signaling. Non-NaN inputs never raise `invalid`.
- R10: `cond`=7 returns 0, keeps `invalid` low and raises `unsupported`. For every other code, `unsupported` is 0.
- R11: Non-NaN values are ordered by sign and magnitude. Infinities are the extremes, and subnormals order normally. -0 is not less than +0.
- R12: While and after reset, `out_valid`, `result`, `invalid` and `unsupported` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| ra | input | 32 | First operand, single precision |
| rb | input | 32 | Second operand, single precision |
| cond | input | 3 | Condition selector, codes 0 to 7 |
| out_valid | output | 1 | Result outputs are valid |
| result | output | 32 | Comparison outcome, 0 or 1 |
| invalid | output | 1 | Invalid-operation flag |
| unsupported | output | 1 | Selector code 7 was presented |

## Verification
The bench compares -0 against +0 under every code. A design that trusts raw bit patterns would report them unequal, or would call the negative zero smaller. Quiet and signaling NaNs are paired with every code: a wrong quiet/signaling split shows up as a missing or stray `invalid` on the equal, not-equal and unordered codes, and a non-complemented code 6 or 5 would return 0 on NaNs. Ordered pairs of negatives, subnormals and infinities catch an operand swap in codes 1 and 4, or a magnitude compare that forgets to reverse for negative values. Code 7 is checked for a stray result or flag.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    CND_UNORD = 3'd0,
    CND_BLTA  = 3'd1,
    CND_EQ    = 3'd2,
    CND_ALEB  = 3'd3,
    CND_ALTB  = 3'd4,
    CND_NE    = 3'd5,
    CND_NLT   = 3'd6,
    CND_RSVD  = 3'd7
  } cond_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic neg;
  } fp_class_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W  = 1 + EXP_W + MAN_W,
  localparam int MAG_W = FP_W - 1
) (
  input  logic [FP_W-1:0]  op,
  output fp_class_t        cls,
  output logic [MAG_W-1:0] mag
);

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  assign expo = op[FP_W-2 -: EXP_W];
  assign frac = op[MAN_W-1:0];

  function automatic logic exp_saturated(input logic [EXP_W-1:0] e);
    return &e;
  endfunction

  function automatic logic is_nan(input logic [EXP_W-1:0] e, input logic [MAN_W-1:0] f);
    return exp_saturated(e) && (|f);
  endfunction

  // Quiet bit is the top fraction bit; a clear quiet bit on a NaN marks it signaling.
  function automatic logic is_snan(input logic [EXP_W-1:0] e, input logic [MAN_W-1:0] f);
    return is_nan(e, f) && !f[MAN_W-1];
  endfunction

  always_comb begin
    cls.nan  = is_nan(expo, frac);
    cls.snan = is_snan(expo, frac);
    cls.zero = ~|op[MAG_W-1:0];
    cls.neg  = op[FP_W-1];
    mag      = op[MAG_W-1:0];
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic             a_lt_b,
  output logic             b_lt_a,
  output logic             a_eq_b,
  output logic             unordered,
  output logic             any_snan
);

  // Strict ordering of two non-NaN values in sign-magnitude form.
  function automatic logic ordered_less(
    input fp_class_t x, input fp_class_t y,
    input logic [MAG_W-1:0] mx, input logic [MAG_W-1:0] my
  );
    logic r;
    if (x.zero && y.zero)   r = 1'b0;
    else if (x.neg != y.neg) r = x.neg;
    else if (!x.neg)        r = (mx < my);
    else                    r = (mx > my);
    return r;
  endfunction

  function automatic logic ordered_equal(
    input fp_class_t x, input fp_class_t y,
    input logic [MAG_W-1:0] mx, input logic [MAG_W-1:0] my
  );
    return (x.zero && y.zero) || ((x.neg == y.neg) && (mx == my));
  endfunction

  always_comb begin
    unordered = cls_a.nan | cls_b.nan;
    any_snan  = cls_a.snan | cls_b.snan;
    a_lt_b    = !unordered && ordered_less(cls_a, cls_b, mag_a, mag_b);
    b_lt_a    = !unordered && ordered_less(cls_b, cls_a, mag_b, mag_a);
    a_eq_b    = !unordered && ordered_equal(cls_a, cls_b, mag_a, mag_b);
  end

endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
  import fcmp_pkg::*;
(
  input  logic [2:0] cond,
  input  logic       a_lt_b,
  input  logic       b_lt_a,
  input  logic       a_eq_b,
  input  logic       unordered,
  input  logic       any_snan,
  output logic       hit,
  output logic       inv,
  output logic       unsup
);

  always_comb begin
    hit   = 1'b0;
    inv   = 1'b0;
    unsup = 1'b0;
    unique case (cond_e'(cond))
      CND_UNORD: begin hit = unordered;         inv = any_snan;  end
      CND_BLTA:  begin hit = b_lt_a;            inv = unordered; end
      CND_EQ:    begin hit = a_eq_b;            inv = any_snan;  end
      CND_ALEB:  begin hit = a_lt_b | a_eq_b;   inv = unordered; end
      CND_ALTB:  begin hit = a_lt_b;            inv = unordered; end
      CND_NE:    begin hit = !a_eq_b;           inv = any_snan;  end
      CND_NLT:   begin hit = !a_lt_b;           inv = unordered; end
      CND_RSVD:  begin unsup = 1'b1;                             end
      default:   begin unsup = 1'b1;                             end
    endcase
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int RES_W   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int FP_W   = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = FP_W - 1,
  localparam int N_OPS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  ra,
  input  logic [FP_W-1:0]  rb,
  input  logic [2:0]       cond,
  output logic             out_valid,
  output logic [RES_W-1:0] result,
  output logic             invalid,
  output logic             unsupported
);

  logic [FP_W-1:0]  ops  [N_OPS];
  fp_class_t        cls  [N_OPS];
  logic [MAG_W-1:0] mags [N_OPS];

  assign ops[0] = ra;
  assign ops[1] = rb;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g]),
      .mag (mags[g])
    );
  end

  // Named events for the checker.
  logic ev_a_lt_b, ev_b_lt_a, ev_eq, ev_unordered, ev_snan;
  logic ev_hit, ev_inv, ev_unsup;

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .cls_a     (cls[0]),
    .cls_b     (cls[1]),
    .mag_a     (mags[0]),
    .mag_b     (mags[1]),
    .a_lt_b    (ev_a_lt_b),
    .b_lt_a    (ev_b_lt_a),
    .a_eq_b    (ev_eq),
    .unordered (ev_unordered),
    .any_snan  (ev_snan)
  );

  fcmp_select u_sel (
    .cond      (cond),
    .a_lt_b    (ev_a_lt_b),
    .b_lt_a    (ev_b_lt_a),
    .a_eq_b    (ev_eq),
    .unordered (ev_unordered),
    .any_snan  (ev_snan),
    .hit       (ev_hit),
    .inv       (ev_inv),
    .unsup     (ev_unsup)
  );

  logic [RES_W-1:0] res_word;
  assign res_word = in_valid ? RES_W'(ev_hit) : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid   <= 1'b0;
        result      <= '0;
        invalid     <= 1'b0;
        unsupported <= 1'b0;
      end else begin
        out_valid   <= in_valid;
        result      <= res_word;
        invalid     <= in_valid & ev_inv;
        unsupported <= in_valid & ev_unsup;
      end
    end
  end else begin : g_comb
    assign out_valid   = in_valid;
    assign result      = res_word;
    assign invalid     = in_valid & ev_inv;
    assign unsupported = in_valid & ev_unsup;
  end

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int RES_W   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       cond,
  input logic             out_valid,
  input logic [RES_W-1:0] result,
  input logic             invalid,
  input logic             unsupported,
  input logic             ev_unordered,
  input logic             ev_snan
);

  AST_RESULT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((result >> 1) == '0)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (result == '0 && !invalid && !unsupported)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid) |=> out_valid); // R1

  AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && cond == 3'd7) |=> (unsupported && result == '0 && !invalid)); // R10

  AST_SNAN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && ev_snan && cond != 3'd7) |=> invalid); // R2

  AST_EQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && (cond == 3'd2 || cond == 3'd5) && !ev_snan) |=> !invalid); // R4

  AST_ORDER_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && in_valid && ev_unordered &&
     (cond == 3'd1 || cond == 3'd3 || cond == 3'd4 || cond == 3'd6))
    |=> (invalid && result == RES_W'($past(cond) == 3'd6))); // R9

endmodule

bind fcmp_unit fcmp_unit_chk #(.RES_W(RES_W), .REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .cond         (cond),
  .out_valid    (out_valid),
  .result       (result),
  .invalid      (invalid),
  .unsupported  (unsupported),
  .ev_unordered (ev_unordered),
  .ev_snan      (ev_snan)
);

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] ra = '0, rb = '0;
  logic [2:0]  cond = '0;
  logic        out_valid, invalid, unsupported;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        inv;
    logic        uns;
    string       tag;
    logic [31:0] a, b;
    logic [2:0]  c;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ra(ra), .rb(rb), .cond(cond),
    .out_valid(out_valid), .result(result), .invalid(invalid), .unsupported(unsupported)
  );

  // Reference model: monotone integer keys instead of sign-magnitude cases.
  function automatic logic nan_of(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic snan_of(input logic [31:0] x);
    return nan_of(x) && !x[22];
  endfunction
  function automatic logic [31:0] key_of(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31])        return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    exp_t e;
    logic un, sn, lt_ab, lt_ba, eq;
    un    = nan_of(a) || nan_of(b);
    sn    = snan_of(a) || snan_of(b);
    lt_ab = !un && (key_of(a) < key_of(b));
    lt_ba = !un && (key_of(b) < key_of(a));
    eq    = !un && (key_of(a) == key_of(b));
    e.a = a; e.b = b; e.c = c; e.uns = 1'b0; e.tag = tag_of(c);
    case (c)
      3'd0: begin e.res = {31'd0, un};            e.inv = sn; end
      3'd1: begin e.res = {31'd0, lt_ba};         e.inv = un; end
      3'd2: begin e.res = {31'd0, eq};            e.inv = sn; end
      3'd3: begin e.res = {31'd0, lt_ab || eq};   e.inv = un; end
      3'd4: begin e.res = {31'd0, lt_ab};         e.inv = un; end
      3'd5: begin e.res = {31'd0, !eq};           e.inv = sn; end
      3'd6: begin e.res = {31'd0, !(un || key_of(a) < key_of(b)) || un}; e.inv = un; end
      default: begin e.res = '0; e.inv = 1'b0; e.uns = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    @(negedge clk);
    in_valid = 1'b1; ra = a; rb = b; cond = c;
    q.push_back(model(a, b, c));
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; ra = '0; rb = '0; cond = '0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1: out_valid with no pending item, actual=%h expected=none", result);
      end else begin
        e = q.pop_front();
        if (result !== e.res || invalid !== e.inv || unsupported !== e.uns) begin
          fails++;
          $display("FAIL %s: a=%h b=%h cond=%0d actual res=%h inv=%b uns=%b expected res=%h inv=%b uns=%b",
                   e.tag, e.a, e.b, e.c, result, invalid, unsupported, e.res, e.inv, e.uns);
        end
      end
    end
  end

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
  localparam logic [31:0] PD = 32'h0000_0001, ND = 32'h8000_0001, PM = 32'h7F7F_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || invalid !== 1'b0 || unsupported !== 1'b0) begin
      fails++;
      $display("FAIL R12: actual v=%b r=%h i=%b u=%b expected all zero", out_valid, result, invalid, unsupported);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R12: after release actual v=%b r=%h expected 0/0", out_valid, result);
    end

    // Every code against directed pairs: R3 R5 R6 ordering, R11 specials, R2 R7 R8 R9 NaNs, R10 code 7
    for (int c = 0; c < 8; c++) begin
      apply(P1, P2, 3'(c));   apply(P2, P1, 3'(c));   apply(P1, P1, 3'(c));
      apply(N1, N2, 3'(c));   apply(N2, N1, 3'(c));   apply(N1, P1, 3'(c));
      apply(PZ, NZ, 3'(c));   apply(NZ, PZ, 3'(c));   // R11 signed zeros
      apply(PI, PM, 3'(c));   apply(NI, N2, 3'(c));   apply(PI, PI, 3'(c));
      apply(PD, PZ, 3'(c));   apply(ND, PZ, 3'(c));   apply(NZ, PD, 3'(c));
      apply(QN, P1, 3'(c));   apply(P1, QN, 3'(c));   apply(SN, P1, 3'(c));
      apply(P1, SN, 3'(c));   apply(QN, QN, 3'(c));   apply(SN, QN, 3'(c));
    end

    // R1: idle cycle gives zero outputs
    go_idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || invalid !== 1'b0 || unsupported !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle actual v=%b r=%h i=%b u=%b expected all zero", out_valid, result, invalid, unsupported);
    end

    // Mixed random operands, some forced to NaN/inf exponents or equal pairs
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (a[3:0] == 0) a[30:23] = 8'hFF;
      if (b[7:4] == 0) b[30:23] = 8'hFF;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) b = {~a[31], a[30:0]};
      apply(a, b, 3'($urandom % 8));
      if (i % 50 == 0) go_idle();
    end

    go_idle();
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d results missing expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule